// File: doc/BRIEF.md
# Pipelined Multi-Mode Color Space Converter

This block converts one three-component pixel on every clock cycle between gamma-corrected RGB and two luma/color-difference representations. A 2-bit mode input picks one of four standard-definition matrices: RGB to YCrCb, YCrCb to RGB, RGB to YUV and YUV to RGB. Every pixel carries its own mode, so streams in different spaces can be interleaved freely on one pipeline.

The datapath has three register stages. The first captures the pixel. The second holds a signed fixed-point multiply-accumulate result built from coefficients scaled by 1024 (10 fractional bits), including any input or output offsets and a rounding constant. The third stores the rounded, saturated 8-bit result. A valid strobe travels alongside the data. Output data registers load only for valid pixels and hold their value otherwise.

Top module: `pixel_space_conv`

## Requirements
- R1: Mode 0 (RGB to YCrCb, inputs R,G,B on channels 0..2, outputs Y,Cr,Cb): Y = 0.257R + 0.504G + 0.098B + 16, Cr = 0.439R - 0.368G - 0.071B + 128, Cb = -0.148R - 0.291G + 0.439B + 128. Each coefficient is rounded to the nearest multiple of 1/1024.
- R2: Mode 1 (YCrCb to RGB, inputs Y,Cr,Cb, outputs R,G,B): with y = Y-16, r = Cr-128, b = Cb-128, R = 1.164y + 1.596r, G = 1.164y - 0.813r - 0.392b, B = 1.164y + 2.017b.
- R3: Mode 2 (RGB to YUV, outputs Y,U,V): Y = 0.299R + 0.587G + 0.114B, U = -0.147R - 0.289G + 0.436B, V = 0.615R - 0.515G - 0.100B. U and V leave as 8-bit two's complement and saturate to -128..127.
- R4: Mode 3 (YUV to RGB, inputs Y unsigned, U and V 8-bit two's complement): R = Y + 1.140V, G = Y - 0.394U - 0.581V, B = Y - 2.032U.
- R5: Each result is the scaled sum plus 512, arithmetically shifted right by 10 (round half up), so mode 0 with R,G,B = 2,0,0 gives Y = 17.
- R6: Every output other than U and V in mode 2 saturates to 0..255.
- R7: A pixel captured at a rising edge with the valid input high appears, with the valid output high, right after the second rising edge that follows; a cycle without valid input yields a cycle with the valid output low at the same distance.
- R8: Pixels are accepted on back-to-back cycles with no stall, and each pixel is converted with the mode sampled in the same cycle, even when the mode changes on every pixel.
- R9: While the valid output is low, the output data hold the last valid result (zero if none since reset).
- R10: A synchronous active-high reset drops the valid output and clears the output data to zero.
- R11: In mode 0, Y always lies in 16..235 and Cr, Cb in 16..240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Input pixel strobe |
| modeIn | input | 2 | Conversion select (0..3, see R1..R4) |
| chanIn0 | input | 8 | Input component 0 (R or Y) |
| chanIn1 | input | 8 | Input component 1 (G, Cr or U) |
| chanIn2 | input | 8 | Input component 2 (B, Cb or V) |
| validOut | output | 1 | Output pixel strobe |
| chanOut0 | output | 8 | Output component 0 (Y or R) |
| chanOut1 | output | 8 | Output component 1 (Cr, U or G) |
| chanOut2 | output | 8 | Output component 2 (Cb, V or B) |

## Verification
On every cycle the assertions check the three-cycle valid latency and the idle gaps it preserves, the clearing of the valid output by reset, the holding of the output data between valid pixels, and the legal luma and chroma ranges of every RGB to YCrCb result. The numeric matrices, the offset handling, the round-half-up step, the saturation at both ends and the per-pixel mode switching are only shown by the bench, which compares each output against values computed from the decimal coefficients over directed extremes and a long randomly mixed stream.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int FRAC_BITS = 10;
  localparam int COEF_W = 13;

  typedef logic signed [COEF_W-1:0] coef_t;

  typedef enum logic [1:0] {
    MODE_RGB2YCC = 2'd0,
    MODE_YCC2RGB = 2'd1,
    MODE_RGB2YUV = 2'd2,
    MODE_YUV2RGB = 2'd3
  } cscMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     ld1;
    logic     ld2;
    logic     ld3;
    cscMode_e macMode;
    cscMode_e clampMode;
  } cscStrobe_t;

  // Matrix entry for output row (idx/3) and input column (idx%3), scaled by 2^10
  function automatic coef_t coefOf(input cscMode_e m, input logic [3:0] idx);
    coef_t k;
    k = '0;
    unique case (m)
      MODE_RGB2YCC:
        case (idx)
          4'd0: k = 13'sd263;   4'd1: k = 13'sd516;   4'd2: k = 13'sd100;
          4'd3: k = 13'sd450;   4'd4: k = -13'sd377;  4'd5: k = -13'sd73;
          4'd6: k = -13'sd152;  4'd7: k = -13'sd298;  4'd8: k = 13'sd450;
          default: k = '0;
        endcase
      MODE_YCC2RGB:
        case (idx)
          4'd0: k = 13'sd1192;  4'd1: k = 13'sd1634;  4'd2: k = 13'sd0;
          4'd3: k = 13'sd1192;  4'd4: k = -13'sd833;  4'd5: k = -13'sd401;
          4'd6: k = 13'sd1192;  4'd7: k = 13'sd0;     4'd8: k = 13'sd2065;
          default: k = '0;
        endcase
      MODE_RGB2YUV:
        case (idx)
          4'd0: k = 13'sd306;   4'd1: k = 13'sd601;   4'd2: k = 13'sd117;
          4'd3: k = -13'sd151;  4'd4: k = -13'sd296;  4'd5: k = 13'sd446;
          4'd6: k = 13'sd630;   4'd7: k = -13'sd527;  4'd8: k = -13'sd102;
          default: k = '0;
        endcase
      MODE_YUV2RGB:
        case (idx)
          4'd0: k = 13'sd1024;  4'd1: k = 13'sd0;     4'd2: k = 13'sd1167;
          4'd3: k = 13'sd1024;  4'd4: k = -13'sd403;  4'd5: k = -13'sd595;
          4'd6: k = 13'sd1024;  4'd7: k = -13'sd2081; 4'd8: k = 13'sd0;
          default: k = '0;
        endcase
    endcase
    return k;
  endfunction

endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  cscMode_e   modeIn,
  output cscStrobe_t strb,
  output logic       validOut
);

  logic     vStage1, vStage2, vStage3;
  cscMode_e modeStage1, modeStage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      vStage1    <= 1'b0;
      vStage2    <= 1'b0;
      vStage3    <= 1'b0;
      modeStage1 <= MODE_RGB2YCC;
      modeStage2 <= MODE_RGB2YCC;
    end else begin
      vStage1 <= validIn;
      vStage2 <= vStage1;
      vStage3 <= vStage2;
      if (validIn) modeStage1 <= modeIn;
      if (vStage1) modeStage2 <= modeStage1;
    end
  end

  always_comb begin
    strb.ld1       = validIn;
    strb.ld2       = vStage1;
    strb.ld3       = vStage2;
    strb.macMode   = modeStage1;
    strb.clampMode = modeStage2;
  end

  assign validOut = vStage3;

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    validIn |-> ##3 validOut);

  // R7
  idle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |-> ##3 !validOut);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !validOut);

endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cscStrobe_t       strb,
  input  logic [PIX_W-1:0] din0,
  input  logic [PIX_W-1:0] din1,
  input  logic [PIX_W-1:0] din2,
  output logic [PIX_W-1:0] dout0,
  output logic [PIX_W-1:0] dout1,
  output logic [PIX_W-1:0] dout2
);

  localparam int OPD_W    = PIX_W + 2;
  localparam int ACC_W    = OPD_W + COEF_W + 2;
  localparam int SH_W     = ACC_W - FRAC_BITS;
  localparam int LUMA_OFF = 1 << (PIX_W - 4);
  localparam int MID_OFF  = 1 << (PIX_W - 1);
  localparam int HALF_LSB = 1 << (FRAC_BITS - 1);
  localparam logic signed [SH_W-1:0] U_HI = SH_W'((1 << PIX_W) - 1);
  localparam logic signed [SH_W-1:0] S_HI = SH_W'(MID_OFF - 1);
  localparam logic signed [SH_W-1:0] S_LO = SH_W'(-MID_OFF);

  logic [PIX_W-1:0]        dinArr [3];
  logic [PIX_W-1:0]        inReg  [3];
  logic signed [OPD_W-1:0] opd    [3];
  logic signed [ACC_W-1:0] accNext[3];
  logic signed [ACC_W-1:0] accReg [3];
  logic [PIX_W-1:0]        satNext[3];
  logic [PIX_W-1:0]        outReg [3];

  assign dinArr[0] = din0;
  assign dinArr[1] = din1;
  assign dinArr[2] = din2;

  // Stage 1: input capture
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) inReg[i] <= '0;
    end else if (strb.ld1) begin
      for (int i = 0; i < 3; i++) inReg[i] <= dinArr[i];
    end
  end

  // Operand forming: input offset removal or signed chroma
  always_comb begin
    for (int l = 0; l < 3; l++) begin
      if (strb.macMode == MODE_YUV2RGB && l != 0)
        opd[l] = OPD_W'($signed(inReg[l]));
      else if (strb.macMode == MODE_YCC2RGB)
        opd[l] = $signed({2'b00, inReg[l]}) - $signed(OPD_W'((l == 0) ? LUMA_OFF : MID_OFF));
      else
        opd[l] = $signed({2'b00, inReg[l]});
    end
  end

  // Multiply-accumulate with output offset and rounding constant
  always_comb begin
    for (int r = 0; r < 3; r++) begin
      accNext[r] = $signed(ACC_W'(HALF_LSB));
      if (strb.macMode == MODE_RGB2YCC)
        accNext[r] = accNext[r] + $signed(ACC_W'(((r == 0) ? LUMA_OFF : MID_OFF) << FRAC_BITS));
      for (int c = 0; c < 3; c++)
        accNext[r] = accNext[r] + ACC_W'(coefOf(strb.macMode, 4'(r * 3 + c))) * ACC_W'(opd[c]);
    end
  end

  // Stage 2: accumulator register
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) accReg[i] <= '0;
    end else if (strb.ld2) begin
      for (int i = 0; i < 3; i++) accReg[i] <= accNext[i];
    end
  end

  // Scale down and saturate
  always_comb begin
    for (int r = 0; r < 3; r++) begin
      logic signed [SH_W-1:0] sh;
      sh = SH_W'(accReg[r] >>> FRAC_BITS);
      if (strb.clampMode == MODE_RGB2YUV && r != 0) begin
        if (sh > S_HI)      satNext[r] = S_HI[PIX_W-1:0];
        else if (sh < S_LO) satNext[r] = S_LO[PIX_W-1:0];
        else                satNext[r] = sh[PIX_W-1:0];
      end else begin
        if (sh < 0)         satNext[r] = '0;
        else if (sh > U_HI) satNext[r] = U_HI[PIX_W-1:0];
        else                satNext[r] = sh[PIX_W-1:0];
      end
    end
  end

  // Stage 3: output register
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) outReg[i] <= '0;
    end else if (strb.ld3) begin
      for (int i = 0; i < 3; i++) outReg[i] <= satNext[i];
    end
  end

  assign dout0 = outReg[0];
  assign dout1 = outReg[1];
  assign dout2 = outReg[2];

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.ld3 |=> ($stable(dout0) && $stable(dout1) && $stable(dout2)));

  // R11
  ycc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.ld3 && strb.clampMode == MODE_RGB2YCC) |=>
      (dout0 >= PIX_W'(LUMA_OFF) && dout0 <= PIX_W'((1 << PIX_W) - 21) &&
       dout1 >= PIX_W'(LUMA_OFF) && dout1 <= PIX_W'((1 << PIX_W) - 16) &&
       dout2 >= PIX_W'(LUMA_OFF) && dout2 <= PIX_W'((1 << PIX_W) - 16)));

endmodule

// File: rtl/pixel_space_conv.sv
module pixel_space_conv
  import csc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic [1:0]       modeIn,
  input  logic [PIX_W-1:0] chanIn0,
  input  logic [PIX_W-1:0] chanIn1,
  input  logic [PIX_W-1:0] chanIn2,
  output logic             validOut,
  output logic [PIX_W-1:0] chanOut0,
  output logic [PIX_W-1:0] chanOut1,
  output logic [PIX_W-1:0] chanOut2
);

  cscStrobe_t strb;

  csc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .modeIn   (cscMode_e'(modeIn)),
    .strb     (strb),
    .validOut (validOut)
  );

  csc_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .din0  (chanIn0),
    .din1  (chanIn1),
    .din2  (chanIn2),
    .dout0 (chanOut0),
    .dout1 (chanOut1),
    .dout2 (chanOut2)
  );

endmodule

// File: tb/sim_pixel_space_conv.sv
`timescale 1ns/1ps
module sim_pixel_space_conv;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       validIn = 1'b0;
  logic [1:0] modeIn = 2'd0;
  logic [7:0] chanIn0 = 8'd0, chanIn1 = 8'd0, chanIn2 = 8'd0;
  logic       validOut;
  logic [7:0] chanOut0, chanOut1, chanOut2;

  always #2 clk = ~clk;

  pixel_space_conv u0 (
    .clk(clk), .rst(rst), .validIn(validIn), .modeIn(modeIn),
    .chanIn0(chanIn0), .chanIn1(chanIn1), .chanIn2(chanIn2),
    .validOut(validOut), .chanOut0(chanOut0), .chanOut1(chanOut1), .chanOut2(chanOut2)
  );

  int    totalCnt = 0;
  int    failCnt = 0;
  bit    done = 1'b0;
  bit    histV [3];
  int    histE [3][3];
  string histT [3];
  int    lastOut [3];
  string modeTag [4] = '{"R1", "R2", "R3", "R4"};

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  // Expected result from the decimal matrices of R1..R6
  task automatic model(input int m, input int a, input int b, input int c,
                       output int e0, output int e1, output int e2);
    real k [9];
    int  x [3];
    int  o [3];
    int  off [3];
    x = '{a, b, c};
    off = '{0, 0, 0};
    case (m)
      0: k = '{0.257, 0.504, 0.098, 0.439, -0.368, -0.071, -0.148, -0.291, 0.439};
      1: k = '{1.164, 1.596, 0.0, 1.164, -0.813, -0.392, 1.164, 0.0, 2.017};
      2: k = '{0.299, 0.587, 0.114, -0.147, -0.289, 0.436, 0.615, -0.515, -0.100};
      default: k = '{1.0, 0.0, 1.140, 1.0, -0.394, -0.581, 1.0, -2.032, 0.0};
    endcase
    if (m == 0) off = '{16, 128, 128};
    if (m == 1) begin x[0] -= 16; x[1] -= 128; x[2] -= 128; end
    if (m == 3) for (int i = 1; i < 3; i++) if (x[i] > 127) x[i] -= 256;
    for (int r = 0; r < 3; r++) begin
      int s;
      s = off[r] * 1024 + 512;
      for (int cc = 0; cc < 3; cc++) s += int'(k[r * 3 + cc] * 1024.0) * x[cc];
      s = s >>> 10;
      if (m == 2 && r > 0) begin
        if (s > 127) s = 127;
        if (s < -128) s = -128;
        s = s & 255;
      end else begin
        if (s > 255) s = 255;
        if (s < 0) s = 0;
      end
      o[r] = s;
    end
    e0 = o[0]; e1 = o[1]; e2 = o[2];
  endtask

  task automatic check(input string tag, input bit expV, input int x0, input int x1, input int x2);
    totalCnt++;
    if (validOut !== expV || chanOut0 !== x0[7:0] || chanOut1 !== x1[7:0] || chanOut2 !== x2[7:0]) begin
      failCnt++;
      $display("FAIL %s: got v=%0b %0d,%0d,%0d expected v=%0b %0d,%0d,%0d",
               tag, validOut, chanOut0, chanOut1, chanOut2, expV, x0, x1, x2);
    end
  endtask

  // Drive one cycle, then check the output that emerges
  task automatic step(input bit v, input int m, input int a, input int b, input int c, input string tag);
    int e0, e1, e2;
    validIn = v; modeIn = 2'(m);
    chanIn0 = 8'(a); chanIn1 = 8'(b); chanIn2 = 8'(c);
    model(m, a, b, c, e0, e1, e2);
    @(posedge clk);
    histV[2] = histV[1]; histE[2] = histE[1]; histT[2] = histT[1];
    histV[1] = histV[0]; histE[1] = histE[0]; histT[1] = histT[0];
    histV[0] = v; histE[0] = '{e0, e1, e2}; histT[0] = tag;
    @(negedge clk);
    if (histV[2]) begin
      check(histT[2], 1'b1, histE[2][0], histE[2][1], histE[2][2]);
      lastOut = histE[2];
    end else begin
      check("R9", 1'b0, lastOut[0], lastOut[1], lastOut[2]);
    end
  endtask

  task automatic doReset(input bit junkValid);
    rst = 1'b1; validIn = junkValid; modeIn = 2'd1;
    chanIn0 = 8'd255; chanIn1 = 8'd255; chanIn2 = 8'd255;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin histV[i] = 1'b0; histE[i] = '{0, 0, 0}; histT[i] = ""; end
    lastOut = '{0, 0, 0};
    // R10: valid low and data zero after reset
    check("R10", 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    @(negedge clk);
    doReset(1'b1);

    // R1 extremes and neutral grey
    step(1, 0, 0, 0, 0, "R1");
    step(1, 0, 255, 255, 255, "R1");
    step(1, 0, 255, 0, 0, "R1");
    // R5 rounding: Y = 17 for 2,0,0
    step(1, 0, 2, 0, 0, "R5");
    // R2 exact black and nominal white
    step(1, 1, 16, 128, 128, "R2");
    step(1, 1, 235, 128, 128, "R2");
    // R6 saturation high and low
    step(1, 1, 255, 255, 255, "R6");
    step(1, 1, 0, 0, 0, "R6");
    step(1, 3, 0, 128, 128, "R6");
    // R3 signed chroma, V clamps to 127
    step(1, 2, 255, 0, 0, "R3");
    step(1, 2, 0, 0, 255, "R3");
    // R4 signed inputs
    step(1, 3, 128, 0, 0, "R4");
    step(1, 3, 100, 200, 60, "R4");
    // R9 hold across idle cycles
    for (int i = 0; i < 5; i++) step(0, 2, 9, 9, 9, "R9");
    // R7 isolated pixel
    step(1, 2, 40, 80, 120, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R9");
    // R8 mode changes on every back-to-back pixel
    for (int i = 0; i < 12; i++)
      step(1, i % 4, (i * 37) % 256, (i * 91 + 5) % 256, (i * 53 + 200) % 256, "R8");

    // Randomly mixed stream
    for (int i = 0; i < 600; i++) begin
      int m;
      m = int'($urandom % 4);
      step(($urandom % 4) != 0, m, int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 256), modeTag[m]);
    end

    // R10 reset with pixels in flight
    step(1, 0, 10, 20, 30, "R1");
    step(1, 1, 50, 60, 70, "R2");
    doReset(1'b1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R10");
    step(1, 2, 200, 100, 50, "R3");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R9");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule